// File: doc/BRIEF.md
# DRAM CAS-before-RAS Refresh Controller

This block keeps an asynchronous DRAM refreshed by issuing periodic CAS-before-RAS refresh cycles. An 8-bit interval counter advances on a tick taken from a power-of-two prescaler of the system clock. When the count reaches a programmable constant, the counter returns to zero and raises a refresh request toward an external bus arbiter. Once the arbiter grants, a strobe sequencer runs a precharge phase, a strobe phase and a completion phase. In the strobe phase CAS goes low before RAS. RAS can be stretched by a programmable number of wait states.

The counter also works as a plain interval timer. Software can write it directly, for example to clear it before refresh is enabled. If the count already lies above a newly written constant, nothing happens until the counter wraps through 255. A self-refresh mode holds both strobes low so that the DRAM refreshes itself. Leaving that mode always passes through one completion phase with both strobes high.

Software programs the block through a single write port. `wr_sel` picks the target: 0 is the counter, 1 is the compare constant and 2 is the control byte. Code 3 writes nothing. The control byte holds these fields:

| Bits | Field |
|------|-------|
| [2:0] | clock select |
| [3] | refresh enable |
| [4] | self-refresh mode |
| [6:5] | wait-state count |
| [7] | long-pitch enable |

Top module: `dram_cbr_refresh`

## Requirements
- R1: After reset the outputs are `cas_n`=1, `ras_n`=1, `ref_req`=0 and `count_o`=0. The clock select, the compare constant and all enables are 0, so the counter stays at 0 until it is programmed.
- R2: The prescaler counts clock edges since reset. With a clock select `s` from 1 to 7, a tick occurs in every cycle where (edges since reset mod 2^s) equals 2^s−1. That is a divide by 2, 4, …, 128. The counter advances by 1 (mod 256) on each tick, and a select of 0 holds it.
- R3: A tick that finds the count equal to the compare constant clears the counter to 0 instead of advancing it. If refresh is enabled and self-refresh mode is off, that same edge raises `ref_req`. A count above a newly written constant produces no request until the counter wraps through 255 and reaches the constant again.
- R4: A software write of the counter takes effect at the edge where it is issued. It has priority over a tick on that edge, and that tick produces no match.
- R5: `ref_req` stays high until it is accepted. Acceptance happens at an edge where `ref_gnt` is 1 and no refresh cycle is in progress. Further matches while the request is pending merge into it, so one grant yields exactly one refresh cycle and leaves nothing queued.
- R6: The edge after acceptance enters the precharge phase, with both strobes still high. Counting output samples from that edge, `cas_n` is low for N+2 cycles starting with the second sample, and `ras_n` is low for N+1 cycles starting with the third sample. Both strobes then return high together. N is the number of wait states.
- R7: N equals the wait-state count field when the long-pitch bit is 1, and N is 0 otherwise.
- R8: With refresh enable and self-refresh mode both 1, `cas_n` goes low two edges after the control write and `ras_n` goes low one edge later. Both stay low while the mode is held, and `ref_req` stays 0.
- R9: After self-refresh is left, both strobes are high for at least the three samples that follow the first edge after the control write. No refresh cycle can start before that.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 counter, 1 compare constant, 2 control, 3 none |
| wr_data | input | 8 | Write data |
| ref_gnt | input | 1 | Bus grant from the arbiter |
| ref_req | output | 1 | Refresh request to the arbiter |
| cas_n | output | 1 | Column strobe, active low, registered |
| ras_n | output | 1 | Row strobe, active low, registered |
| count_o | output | 8 | Current refresh counter value |

## Verification
Counter writes and ticks appear on `count_o` one edge after the cycle in which they occur. A match raises `ref_req` on the same edge that clears the counter. The bench therefore steps a cycle model at each rising edge and compares it with the outputs at the following falling edge. The strobe checks start counting samples at the edge that accepts the grant. CAS must first be low one sample after the precharge phase and RAS one sample later, with low widths of N+2 and N+1. Self-refresh entry is checked at the second and third samples after the control write, and exit at the first three samples after it.

// File: rtl/dcr_pkg.sv
package dcr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_TRP  = 3'd1,
    ST_TRR  = 3'd2,
    ST_TRC  = 3'd3,
    ST_SELF = 3'd4
  } dcr_state_t;

  localparam logic [1:0] SEL_COUNT = 2'd0;
  localparam logic [1:0] SEL_CMP   = 2'd1;
  localparam logic [1:0] SEL_CTRL  = 2'd2;

endpackage

// File: rtl/dcr_prescaler.sv
module dcr_prescaler #(
  parameter int unsigned SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  localparam int unsigned DIV_W = (1 << SEL_W) - 1;

  logic [DIV_W-1:0] div_q;

  // low-order mask of 'code' ones; code 0 gives an empty mask
  function automatic logic [DIV_W-1:0] sel_mask(input logic [SEL_W-1:0] code);
    logic [DIV_W:0] one;
    one = {{DIV_W{1'b0}}, 1'b1};
    sel_mask = DIV_W'((one << code) - one);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_q + 1'b1;
  end

  logic [DIV_W-1:0] mask_w;
  assign mask_w = sel_mask(sel);
  assign tick   = (sel != '0) && ((div_q & mask_w) == mask_w);

endmodule

// File: rtl/dcr_counter.sv
module dcr_counter #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             wr_cnt,
  input  logic [CNT_W-1:0] wr_val,
  input  logic [CNT_W-1:0] cmp,
  output logic [CNT_W-1:0] count,
  output logic             match
);
  logic [CNT_W-1:0] count_q;

  function automatic logic [CNT_W-1:0] advance(input logic [CNT_W-1:0] c,
                                               input logic hit);
    advance = hit ? '0 : c + 1'b1;
  endfunction

  assign match = tick && !wr_cnt && (count_q == cmp);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      count_q <= '0;
    else if (wr_cnt) count_q <= wr_val;
    else if (tick)   count_q <= advance(count_q, match);
  end

  assign count = count_q;

  AST_COUNT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !wr_cnt) |=> $stable(count_q)); // R2
  AST_CLEAR_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    match |=> (count_q == '0)); // R3
  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cnt |=> (count_q == $past(wr_val))); // R4

endmodule

// File: rtl/dcr_strobe_fsm.sv
module dcr_strobe_fsm
  import dcr_pkg::*;
#(
  parameter int unsigned WS_W = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            match,
  input  logic            req_allow,
  input  logic            sr_cmd,
  input  logic            ref_gnt,
  input  logic            long_pitch,
  input  logic [WS_W-1:0] ws_sel,
  output logic            ref_req,
  output logic            cas_n,
  output logic            ras_n
);
  dcr_state_t      state_q, state_d;
  logic [WS_W-1:0] wcnt_q;
  logic            req_q, cas_n_q, ras_n_q;
  logic            grant_take, cas_on, ras_on;
  logic [WS_W-1:0] n_waits;

  function automatic logic [WS_W-1:0] eff_waits(input logic lp,
                                                input logic [WS_W-1:0] w);
    eff_waits = lp ? w : '0;
  endfunction

  assign n_waits    = eff_waits(long_pitch, ws_sel);
  assign grant_take = (state_q == ST_IDLE) && req_q && ref_gnt && !sr_cmd;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (sr_cmd)          state_d = ST_SELF;
        else if (grant_take) state_d = ST_TRP;
      end
      ST_TRP:  state_d = ST_TRR;
      ST_TRR:  if (wcnt_q == n_waits) state_d = ST_TRC;
      ST_TRC:  state_d = ST_IDLE;
      ST_SELF: if (!sr_cmd) state_d = ST_TRC;
      default: state_d = ST_IDLE;
    endcase
  end

  assign cas_on = (state_q == ST_TRP) || (state_q == ST_TRR) ||
                  ((state_q == ST_SELF) && sr_cmd);
  assign ras_on = (state_q == ST_TRR) ||
                  ((state_q == ST_SELF) && sr_cmd && !cas_n_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      wcnt_q  <= '0;
      req_q   <= 1'b0;
      cas_n_q <= 1'b1;
      ras_n_q <= 1'b1;
    end else begin
      state_q <= state_d;
      wcnt_q  <= (state_q == ST_TRR) ? wcnt_q + 1'b1 : '0;
      if (!req_allow)      req_q <= 1'b0;
      else if (match)      req_q <= 1'b1;
      else if (grant_take) req_q <= 1'b0;
      cas_n_q <= !cas_on;
      ras_n_q <= !ras_on;
    end
  end

  assign ref_req = req_q;
  assign cas_n   = cas_n_q;
  assign ras_n   = ras_n_q;

  AST_CAS_LEADS_RAS: assert property (@(posedge clk) disable iff (!rst_n)
    !ras_n_q |-> !cas_n_q); // R6
  AST_GRANT_PRECHARGE: assert property (@(posedge clk) disable iff (!rst_n)
    grant_take |=> (cas_n_q && ras_n_q)); // R6
  AST_SELF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_SELF) && sr_cmd) |=> !cas_n_q); // R8
  AST_NO_REQ_IN_SELF: assert property (@(posedge clk) disable iff (!rst_n)
    sr_cmd |=> !req_q); // R8
  AST_SELF_EXIT_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_SELF) && !sr_cmd) |=> (cas_n_q && ras_n_q)); // R9

endmodule

// File: rtl/dram_cbr_refresh.sv
module dram_cbr_refresh
  import dcr_pkg::*;
#(
  parameter int unsigned CNT_W = 8,
  parameter int unsigned SEL_W = 3,
  parameter int unsigned WS_W  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             ref_gnt,
  output logic             ref_req,
  output logic             cas_n,
  output logic             ras_n,
  output logic [CNT_W-1:0] count_o
);
  localparam int unsigned EN_BIT   = SEL_W;
  localparam int unsigned MODE_BIT = SEL_W + 1;
  localparam int unsigned WS_LSB   = SEL_W + 2;
  localparam int unsigned LP_BIT   = SEL_W + 2 + WS_W;

  logic [SEL_W-1:0] sel_q;
  logic [CNT_W-1:0] cmp_q;
  logic [WS_W-1:0]  ws_q;
  logic             en_q, mode_q, lp_q;
  logic             wr_cnt, tick, match, req_allow, sr_cmd;

  assign wr_cnt    = wr_en && (wr_sel == SEL_COUNT);
  assign req_allow = en_q && !mode_q;
  assign sr_cmd    = en_q && mode_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= '0;
      cmp_q  <= '0;
      ws_q   <= '0;
      en_q   <= 1'b0;
      mode_q <= 1'b0;
      lp_q   <= 1'b0;
    end else if (wr_en) begin
      if (wr_sel == SEL_CMP) cmp_q <= wr_data;
      if (wr_sel == SEL_CTRL) begin
        sel_q  <= wr_data[SEL_W-1:0];
        en_q   <= wr_data[EN_BIT];
        mode_q <= wr_data[MODE_BIT];
        ws_q   <= wr_data[WS_LSB +: WS_W];
        lp_q   <= wr_data[LP_BIT];
      end
    end
  end

  dcr_prescaler #(.SEL_W(SEL_W)) u_pre (
    .clk  (clk),
    .rst_n(rst_n),
    .sel  (sel_q),
    .tick (tick)
  );

  dcr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick),
    .wr_cnt(wr_cnt),
    .wr_val(wr_data),
    .cmp   (cmp_q),
    .count (count_o),
    .match (match)
  );

  dcr_strobe_fsm #(.WS_W(WS_W)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .match     (match),
    .req_allow (req_allow),
    .sr_cmd    (sr_cmd),
    .ref_gnt   (ref_gnt),
    .long_pitch(lp_q),
    .ws_sel    (ws_q),
    .ref_req   (ref_req),
    .cas_n     (cas_n),
    .ras_n     (ras_n)
  );

  AST_MATCH_REQUESTS: assert property (@(posedge clk) disable iff (!rst_n)
    (match && req_allow) |=> ref_req); // R3
  AST_SEL_ZERO_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_q == '0) |-> !match); // R2

endmodule

// File: tb/dram_cbr_refresh_tb.sv
module dram_cbr_refresh_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_sel = 2'd3;
  logic [7:0] wr_data = 8'd0;
  logic       ref_gnt = 1'b0;
  logic       ref_req, cas_n, ras_n;
  logic [7:0] count_o;

  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;

  dram_cbr_refresh u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .ref_gnt(ref_gnt), .ref_req(ref_req),
    .cas_n(cas_n), .ras_n(ras_n), .count_o(count_o)
  );

  // ---------------- reference model, stepped at each rising edge --------
  int   mcyc;
  logic [7:0] mcount, mcmp;
  logic [2:0] msel;
  logic men, mmode, mreq;

  function automatic bit tick_due(int cyc, logic [2:0] s);
    int period;
    if (s == 3'd0) return 1'b0;
    period = 1 << s;
    return ((cyc % 128) % period) == (period - 1);
  endfunction

  function automatic logic [7:0] ctrl_byte(bit lp, int ws, bit mode, bit en, int s);
    return {lp, 2'(ws), mode, en, 3'(s)};
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      mcyc = 0; mcount = 8'd0; mcmp = 8'd0; msel = 3'd0;
      men = 1'b0; mmode = 1'b0; mreq = 1'b0;
    end else begin
      bit hit;
      hit = 1'b0;
      if (wr_en && wr_sel == 2'd0) mcount = wr_data;
      else if (tick_due(mcyc, msel)) begin
        if (mcount == mcmp) begin mcount = 8'd0; hit = 1'b1; end
        else mcount = mcount + 8'd1;
      end
      if (!men || mmode) mreq = 1'b0;
      else if (hit) mreq = 1'b1;
      if (wr_en && wr_sel == 2'd1) mcmp = wr_data;
      if (wr_en && wr_sel == 2'd2) begin
        msel = wr_data[2:0]; men = wr_data[3]; mmode = wr_data[4];
      end
      mcyc = mcyc + 1;
    end
  end

  // ---------------- helpers ---------------------------------------------
  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] s, logic [7:0] d);
    wr_en = 1'b1; wr_sel = s; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_sel = 2'd3;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; wr_en = 1'b0; ref_gnt = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic model_step_check(string tag);
    chk(count_o == mcount, {tag, " count"}, count_o, mcount);
    chk(ref_req == mreq, {tag, " ref_req"}, ref_req, mreq);
  endtask

  // one refresh cycle with pending merged matches; expected N waits
  task automatic run_cbr(bit lp, int ws, int n_exp);
    int cas_lo, ras_lo, cas_first, ras_first;
    do_reset();
    wr(2'd1, 8'd0);
    wr(2'd2, ctrl_byte(lp, ws, 1'b0, 1'b1, 1));
    repeat (20) @(negedge clk);
    chk(ref_req == 1'b1, "R5 request held while pending", ref_req, 1);
    wr(2'd2, ctrl_byte(lp, ws, 1'b0, 1'b1, 0));
    repeat (2) @(negedge clk);
    cas_lo = 0; ras_lo = 0; cas_first = 0; ras_first = 0;
    ref_gnt = 1'b1;
    for (int i = 1; i <= 12; i++) begin
      @(negedge clk);
      if (i == 1) begin
        ref_gnt = 1'b0;
        chk(ref_req == 1'b0, "R5 request dropped on grant", ref_req, 0);
        chk(cas_n && ras_n, "R6 precharge strobes high", {cas_n, ras_n}, 3);
      end
      if (!cas_n) begin cas_lo++; if (cas_first == 0) cas_first = i; end
      if (!ras_n) begin ras_lo++; if (ras_first == 0) ras_first = i; end
    end
    chk(cas_first == 2, "R6 CAS first low sample", cas_first, 2);
    chk(ras_first == 3, "R6 RAS first low sample", ras_first, 3);
    chk(cas_lo == n_exp + 2, "R7 CAS low width", cas_lo, n_exp + 2);
    chk(ras_lo == n_exp + 1, "R7 RAS low width", ras_lo, n_exp + 1);
    chk(ref_req == 1'b0, "R5 merged matches leave nothing queued", ref_req, 0);
  endtask

  // ---------------- watchdog --------------------------------------------
  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  // ---------------- main sequence ---------------------------------------
  initial begin
    logic [7:0] held;
    void'($urandom(32'd20240611));
    do_reset();

    // R1 reset state
    chk(cas_n == 1'b1, "R1 cas_n after reset", cas_n, 1);
    chk(ras_n == 1'b1, "R1 ras_n after reset", ras_n, 1);
    chk(ref_req == 1'b0, "R1 ref_req after reset", ref_req, 0);
    chk(count_o == 8'd0, "R1 count after reset", count_o, 0);
    repeat (40) @(negedge clk);
    chk(count_o == 8'd0, "R1 counter idle with select 0", count_o, 0);

    // R3 stale count above a new constant waits for the wrap
    wr(2'd1, 8'd10);
    wr(2'd0, 8'd200);
    wr(2'd2, ctrl_byte(0, 0, 0, 1, 1));
    repeat (100) begin @(negedge clk); model_step_check("R3 stale"); end
    chk(ref_req == 1'b0, "R3 no request before wrap", ref_req, 0);
    repeat (60) begin @(negedge clk); model_step_check("R3 stale"); end
    chk(ref_req == 1'b1, "R3 request after wrap", ref_req, 1);

    // R4 software write of the counter wins over a tick
    wr(2'd0, 8'd77);
    chk(count_o == 8'd77, "R4 counter write", count_o, 77);
    @(negedge clk);
    chk(count_o == 8'd77 || count_o == 8'd78, "R4 counter after write", count_o, 78);

    // R2 select 0 holds the counter
    wr(2'd2, ctrl_byte(0, 0, 0, 1, 0));
    held = count_o;
    repeat (30) @(negedge clk);
    chk(count_o == held, "R2 select 0 holds count", count_o, held);

    // R2 R3 randomized rounds against the model
    for (int r = 0; r < 20; r++) begin
      do_reset();
      wr(2'd1, 8'($urandom_range(0, 40)));
      wr(2'd0, 8'($urandom_range(0, 255)));
      wr(2'd2, ctrl_byte(0, 0, 0, 1, $urandom_range(1, 4)));
      for (int c = 0; c < 350; c++) begin
        @(negedge clk);
        model_step_check("R2 R3 random");
        wr_en = 1'b0; wr_sel = 2'd3;
        if ($urandom_range(0, 39) == 0) begin
          int k;
          k = $urandom_range(0, 2);
          wr_en = 1'b1;
          wr_sel = 2'(k);
          if (k == 2) wr_data = ctrl_byte(0, 0, 0, 1, $urandom_range(0, 4));
          else if (k == 1) wr_data = 8'($urandom_range(0, 40));
          else wr_data = 8'($urandom_range(0, 255));
        end
      end
      @(negedge clk);
      wr_en = 1'b0; wr_sel = 2'd3;
    end

    // R6 R7 refresh cycle shapes
    run_cbr(1'b0, 3, 0);
    for (int w = 0; w < 4; w++) run_cbr(1'b1, w, w);

    // R8 self-refresh entry and hold
    do_reset();
    wr(2'd1, 8'd0);
    wr(2'd2, ctrl_byte(0, 0, 1, 1, 1));
    @(negedge clk);
    @(negedge clk);
    chk(!cas_n && ras_n, "R8 CAS first on entry", {cas_n, ras_n}, 1);
    @(negedge clk);
    chk(!cas_n && !ras_n, "R8 both strobes low", {cas_n, ras_n}, 0);
    repeat (30) @(negedge clk);
    chk(!cas_n && !ras_n, "R8 strobes held low", {cas_n, ras_n}, 0);
    chk(ref_req == 1'b0, "R8 no request in self-refresh", ref_req, 0);

    // R9 exit with grant held high and matches running
    ref_gnt = 1'b1;
    wr(2'd2, ctrl_byte(0, 0, 0, 1, 1));
    for (int i = 1; i <= 3; i++) begin
      @(negedge clk);
      chk(cas_n && ras_n, "R9 strobes high after exit", {cas_n, ras_n}, 3);
    end
    ref_gnt = 1'b0;
    repeat (10) @(negedge clk);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule